// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Controller

This block steers operands in a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). It looks at the register numbers, write enables and load/store flags held in the three pipeline registers downstream of decode. From them it produces the select codes for the two ALU operand muxes in execute and a select for the data-memory write-data mux in the memory stage. When a load's result is needed by the very next instruction's execute stage, and no path can deliver it in time, it raises a single stall that freezes the program counter and the fetch/decode register and injects a no-op into the decode/execute register.

The block also holds the integer register file. The file is read in decode and written from writeback. A write in a given cycle is visible to a read of the same register in that same cycle. Register 0 is hard-wired to zero. A load that is followed directly by a store of the loaded value does not stall, because the store picks up its write data from the writeback register when it reaches the memory stage.

Top module: `hazard_fwd_unit`

## Requirements
- R1: An ALU operand select (`fwdSelA`/`fwdSelB`) is `01` (take the memory-stage result) when that operand's use flag is set, the memory-stage instruction writes, and its destination equals the operand's nonzero source number.
- R2: An ALU operand select is `10` (take the writeback-stage result) when the use flag is set, the writeback instruction writes a nonzero destination equal to the source, and the memory stage does not match. In every other case the select is `00` (register-file value).
- R3: When both the memory and writeback stages match the same source, the select is `01`.
- R4: Register 0 reads as zero, and a write to it changes nothing. A destination of 0 never produces a nonzero select, a store-data forward or a stall.
- R5: A read of a register that writeback is writing in the same cycle returns the new write data.
- R6: A value written to a nonzero register is returned by every later read until that register is written again.
- R7: `storeFwd` is 1 exactly when the memory-stage instruction is a store, writeback writes a nonzero destination, and that destination equals the store's data source register.
- R8: `pcHold`, `ifIdHold` and `idExBubble` rise together, and only together. They rise when the execute-stage instruction is a load writing nonzero register d, and the decode instruction uses d as its first operand, or uses d as its second operand and is not a store. Once the no-op (write enable cleared) is in execute, they fall, so exactly one bubble is inserted.
- R9: A decode-stage store whose only match with an execute-stage load is its data source does not stall.
- R10: A source whose use flag is clear (for example, an immediate second operand) never causes a forward or a stall.
- R11: After reset every register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| idRs1 | input | REG_AW | Decode-stage first source register |
| idRs2 | input | REG_AW | Decode-stage second source register |
| idUseRs1 | input | 1 | Decode instruction reads its first source |
| idUseRs2 | input | 1 | Decode instruction reads its second source |
| idIsStore | input | 1 | Decode instruction is a store |
| exRs1 | input | REG_AW | Execute-stage first source |
| exRs2 | input | REG_AW | Execute-stage second source |
| exUseRs1 | input | 1 | Execute instruction reads first source |
| exUseRs2 | input | 1 | Execute instruction reads second source |
| exRd | input | REG_AW | Execute-stage destination |
| exWe | input | 1 | Execute instruction writes a register |
| exIsLoad | input | 1 | Execute instruction is a load |
| memRd | input | REG_AW | Memory-stage destination |
| memWe | input | 1 | Memory-stage instruction writes a register |
| memIsStore | input | 1 | Memory-stage instruction is a store |
| memRs2 | input | REG_AW | Memory-stage store data source |
| wbRd | input | REG_AW | Writeback destination |
| wbWe | input | 1 | Writeback write enable |
| wbData | input | DATA_W | Writeback result |
| rdData1 | output | DATA_W | Register-file read of idRs1 |
| rdData2 | output | DATA_W | Register-file read of idRs2 |
| fwdSelA | output | 2 | ALU operand A select: 00 file, 01 memory stage, 10 writeback |
| fwdSelB | output | 2 | ALU operand B select, same coding |
| storeFwd | output | 1 | Memory write data taken from writeback |
| pcHold | output | 1 | Freeze program counter |
| ifIdHold | output | 1 | Freeze fetch/decode register |
| idExBubble | output | 1 | Load a no-op into decode/execute register |

## Verification
The bench sweeps every combination of the registers 0 to 7 across the producer and consumer fields, together with all the enable, use and type flags. A design that ranked the writeback stage above the memory stage would hand an instruction a stale operand. One that forgot the register-0 guard would forward or stall on writes that are discarded. One that ignored use flags would stall on immediates. One that treated store data like an ALU operand would insert a bubble the store-data path makes unnecessary. Directed sequences check the same-cycle file bypass, the ignored write to register 0, and the fact that the injected no-op ends the stall after one cycle.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

  typedef enum logic [1:0] {
    FWD_RF    = 2'b00,
    FWD_EXMEM = 2'b01,
    FWD_MEMWB = 2'b10
  } fwdSel_e;

  // strobes handed from control to the datapath/top
  typedef struct packed {
    fwdSel_e fwdA;
    fwdSel_e fwdB;
    logic    storeFwd;
    logic    stall;
  } hazCtl_t;

endpackage

// File: rtl/hazard_regfile.sv
module hazard_regfile #(
  parameter int REG_AW = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] rdAddr [2],
  output logic [DATA_W-1:0] rdData [2],
  input  logic              wrEn,
  input  logic [REG_AW-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData
);
  localparam int NREGS = 1 << REG_AW;

  logic [DATA_W-1:0] regs [NREGS];
  logic              wrLive;

  assign wrLive = wrEn && (wrAddr != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (wrLive) begin
      regs[wrAddr] <= wrData;
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_port
    always_comb begin
      if (rdAddr[p] == '0)                       rdData[p] = '0;
      else if (wrLive && (wrAddr == rdAddr[p]))  rdData[p] = wrData;
      else                                       rdData[p] = regs[rdAddr[p]];
    end

    AST_RF_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      (rdAddr[p] == '0) |-> (rdData[p] == '0));                          // R4
    AST_RF_BYPASS: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && wrAddr != '0 && wrAddr == rdAddr[p]) |-> (rdData[p] == wrData)); // R5
  end

  AST_RF_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr != '0) |=> (regs[$past(wrAddr)] == $past(wrData)));   // R6
  AST_RF_R0_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (regs[0] == '0));                                                    // R4

endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hazard_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] idSrc [2],
  input  logic [1:0]        idUse,
  input  logic              idIsStore,
  input  logic [REG_AW-1:0] exSrc [2],
  input  logic [1:0]        exUse,
  input  logic [REG_AW-1:0] exRd,
  input  logic              exWe,
  input  logic              exIsLoad,
  input  logic [REG_AW-1:0] memRd,
  input  logic              memWe,
  input  logic              memIsStore,
  input  logic [REG_AW-1:0] memRs2,
  input  logic [REG_AW-1:0] wbRd,
  input  logic              wbWe,
  output hazCtl_t           ctl
);
  logic    memLive, wbLive, loadLive;
  fwdSel_e opSel  [2];
  logic    useHit [2];

  assign memLive  = memWe && (memRd != '0);
  assign wbLive   = wbWe  && (wbRd  != '0);
  assign loadLive = exIsLoad && exWe && (exRd != '0);

  for (genvar k = 0; k < 2; k++) begin : g_op
    // younger producer (memory stage) checked first
    always_comb begin
      opSel[k] = FWD_RF;
      if (exUse[k] && memLive && (memRd == exSrc[k]))     opSel[k] = FWD_EXMEM;
      else if (exUse[k] && wbLive && (wbRd == exSrc[k]))  opSel[k] = FWD_MEMWB;
    end

    AST_NO_FWD_UNUSED: assert property (@(posedge clk) disable iff (!rstN)
      !exUse[k] |-> (opSel[k] == FWD_RF));                               // R10
    AST_YOUNGER_WINS: assert property (@(posedge clk) disable iff (!rstN)
      (exUse[k] && memWe && memRd != '0 && memRd == exSrc[k]) |-> (opSel[k] == FWD_EXMEM)); // R3
    AST_FWD_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
      (exSrc[k] == '0) |-> (opSel[k] == FWD_RF));                        // R4
  end

  // store data source (second operand) needs no interlock: it is forwarded in the memory stage
  assign useHit[0] = idUse[0] && (idSrc[0] == exRd);
  assign useHit[1] = idUse[1] && !idIsStore && (idSrc[1] == exRd);

  always_comb begin
    ctl.fwdA     = opSel[0];
    ctl.fwdB     = opSel[1];
    ctl.storeFwd = memIsStore && wbLive && (wbRd == memRs2);
    ctl.stall    = loadLive && (useHit[0] || useHit[1]);
  end

  AST_STALL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stall |-> (exIsLoad && exWe && exRd != '0));                     // R8
  AST_NOP_ENDS_STALL: assert property (@(posedge clk) disable iff (!rstN)
    !exWe |-> !ctl.stall);                                               // R8
  AST_STFWD_NEEDS_STORE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.storeFwd |-> (memIsStore && wbWe && wbRd != '0));                // R7

endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
  import hazard_pkg::*;
#(
  parameter int REG_AW = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] idRs1,
  input  logic [REG_AW-1:0] idRs2,
  input  logic              idUseRs1,
  input  logic              idUseRs2,
  input  logic              idIsStore,
  input  logic [REG_AW-1:0] exRs1,
  input  logic [REG_AW-1:0] exRs2,
  input  logic              exUseRs1,
  input  logic              exUseRs2,
  input  logic [REG_AW-1:0] exRd,
  input  logic              exWe,
  input  logic              exIsLoad,
  input  logic [REG_AW-1:0] memRd,
  input  logic              memWe,
  input  logic              memIsStore,
  input  logic [REG_AW-1:0] memRs2,
  input  logic [REG_AW-1:0] wbRd,
  input  logic              wbWe,
  input  logic [DATA_W-1:0] wbData,
  output logic [DATA_W-1:0] rdData1,
  output logic [DATA_W-1:0] rdData2,
  output logic [1:0]        fwdSelA,
  output logic [1:0]        fwdSelB,
  output logic              storeFwd,
  output logic              pcHold,
  output logic              ifIdHold,
  output logic              idExBubble
);
  hazCtl_t           ctl;
  logic [REG_AW-1:0] idSrc  [2];
  logic [REG_AW-1:0] exSrc  [2];
  logic [DATA_W-1:0] rfData [2];

  assign idSrc[0] = idRs1;
  assign idSrc[1] = idRs2;
  assign exSrc[0] = exRs1;
  assign exSrc[1] = exRs2;

  hazard_ctrl #(.REG_AW(REG_AW)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .idSrc     (idSrc),
    .idUse     ({idUseRs2, idUseRs1}),
    .idIsStore (idIsStore),
    .exSrc     (exSrc),
    .exUse     ({exUseRs2, exUseRs1}),
    .exRd      (exRd),
    .exWe      (exWe),
    .exIsLoad  (exIsLoad),
    .memRd     (memRd),
    .memWe     (memWe),
    .memIsStore(memIsStore),
    .memRs2    (memRs2),
    .wbRd      (wbRd),
    .wbWe      (wbWe),
    .ctl       (ctl)
  );

  hazard_regfile #(.REG_AW(REG_AW), .DATA_W(DATA_W)) u_rf (
    .clk   (clk),
    .rstN  (rstN),
    .rdAddr(idSrc),
    .rdData(rfData),
    .wrEn  (wbWe),
    .wrAddr(wbRd),
    .wrData(wbData)
  );

  assign rdData1    = rfData[0];
  assign rdData2    = rfData[1];
  assign fwdSelA    = ctl.fwdA;
  assign fwdSelB    = ctl.fwdB;
  assign storeFwd   = ctl.storeFwd;
  assign pcHold     = ctl.stall;
  assign ifIdHold   = ctl.stall;
  assign idExBubble = ctl.stall;

  AST_STALL_TRIO: assert property (@(posedge clk) disable iff (!rstN)
    (pcHold == ifIdHold) && (ifIdHold == idExBubble));                   // R8
  AST_STORE_NO_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (idIsStore && !idUseRs1) |-> !pcHold);                               // R9

endmodule

// File: tb/hazard_fwd_unit_tb.sv
module hazard_fwd_unit_tb;
  localparam int AW = 5;
  localparam int DW = 32;

  logic clk = 1'b0, rstN = 1'b0;
  logic [AW-1:0] idRs1 = '0, idRs2 = '0, exRs1 = '0, exRs2 = '0, exRd = '0;
  logic [AW-1:0] memRd = '0, memRs2 = '0, wbRd = '0;
  logic idUseRs1 = 0, idUseRs2 = 0, idIsStore = 0, exUseRs1 = 0, exUseRs2 = 0;
  logic exWe = 0, exIsLoad = 0, memWe = 0, memIsStore = 0, wbWe = 0;
  logic [DW-1:0] wbData = '0;
  logic [DW-1:0] rdData1, rdData2;
  logic [1:0] fwdSelA, fwdSelB;
  logic storeFwd, pcHold, ifIdHold, idExBubble;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hazard_fwd_unit #(.REG_AW(AW), .DATA_W(DW)) u_dut (.*);

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp, string what);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  function automatic logic [DW-1:0] pattern(int r);
    return (32'h01010101 * r) ^ 32'hA5C3_0F00;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #2;
    // R11 reset state
    check("R11", {28'b0, pcHold, ifIdHold, idExBubble, storeFwd}, 32'h0, "stall/store after reset");
    check("R11", {28'b0, fwdSelA, fwdSelB}, 32'h0, "selects after reset");
    for (int r = 1; r < 8; r++) begin
      idRs1 = AW'(r); idRs2 = AW'(r + 8); #1;
      check("R11", rdData1, '0, "reg cleared port1");
      check("R11", rdData2, '0, "reg cleared port2");
    end

    // R5 same-cycle bypass, then R6 persistence
    @(negedge clk);
    wbWe = 1; wbRd = 5'd5; wbData = 32'hDEAD_BEEF; idRs1 = 5'd5; idRs2 = 5'd6; #2;
    check("R5", rdData1, 32'hDEAD_BEEF, "bypass port1");
    check("R6", rdData2, '0, "unwritten reg");
    @(negedge clk);
    wbWe = 0; idRs2 = 5'd5; #2;
    check("R6", rdData1, 32'hDEAD_BEEF, "persist port1");
    check("R5", rdData2, 32'hDEAD_BEEF, "persist port2");

    // R4 write to register 0 discarded
    @(negedge clk);
    wbWe = 1; wbRd = '0; wbData = 32'hFFFF_FFFF; idRs1 = '0; #2;
    check("R4", rdData1, '0, "r0 during write");
    @(negedge clk);
    wbWe = 0; #2;
    check("R4", rdData1, '0, "r0 after write");

    // R6 fill all registers then read back
    for (int r = 1; r < 32; r++) begin
      @(negedge clk); wbWe = 1; wbRd = AW'(r); wbData = pattern(r);
    end
    @(negedge clk); wbWe = 0;
    for (int r = 0; r < 32; r++) begin
      idRs1 = AW'(r); idRs2 = AW'(31 - r); #1;
      check("R6", rdData1, (r == 0) ? '0 : pattern(r), "readback port1");
      check("R6", rdData2, (r == 31) ? '0 : pattern(31 - r), "readback port2");
    end

    // operand forwarding sweep (R1 R2 R3 R4 R10)
    wbData = '0;
    for (int s = 0; s < 8; s++)
      for (int m = 0; m < 8; m++)
        for (int w = 0; w < 8; w++)
          for (int f = 0; f < 8; f++) begin
            logic mh, wh, us;
            logic [1:0] exp;
            string tag;
            us = f[0];
            exRs1 = AW'(s); exRs2 = AW'(s); exUseRs1 = us; exUseRs2 = us;
            memRd = AW'(m); memWe = f[1]; wbRd = AW'(w); wbWe = f[2];
            mh = us && f[1] && m != 0 && m == s;
            wh = us && f[2] && w != 0 && w == s;
            exp = mh ? 2'b01 : (wh ? 2'b10 : 2'b00);
            if (!us) tag = "R10";
            else if (s == 0) tag = "R4";
            else if (mh && wh) tag = "R3";
            else if (mh) tag = "R1";
            else tag = "R2";
            #1;
            check(tag, {30'b0, fwdSelA}, {30'b0, exp}, "operand A select");
            check(tag, {30'b0, fwdSelB}, {30'b0, exp}, "operand B select");
          end
    exUseRs1 = 0; exUseRs2 = 0; memWe = 0; wbWe = 0;

    // store-data forward sweep (R7 R4)
    for (int a = 0; a < 8; a++)
      for (int w = 0; w < 8; w++)
        for (int f = 0; f < 4; f++) begin
          logic exp;
          memIsStore = f[0]; wbWe = f[1]; memRs2 = AW'(a); wbRd = AW'(w);
          exp = f[0] && f[1] && w != 0 && w == a;
          #1;
          check((w == 0) ? "R4" : "R7", {31'b0, storeFwd}, {31'b0, exp}, "store data forward");
        end
    memIsStore = 0; wbWe = 0;

    // load-use interlock sweep (R8 R9 R10 R4)
    for (int d = 0; d < 8; d++)
      for (int r1 = 0; r1 < 8; r1++)
        for (int r2 = 0; r2 < 8; r2++)
          for (int f = 0; f < 32; f++) begin
            logic ld, h1, h2, st, exps;
            string tag;
            exIsLoad = f[0]; exWe = f[1]; idUseRs1 = f[2]; idUseRs2 = f[3]; idIsStore = f[4];
            exRd = AW'(d); idRs1 = AW'(r1); idRs2 = AW'(r2);
            ld = f[0] && f[1] && d != 0;
            h1 = f[2] && r1 == d;
            h2 = f[3] && r2 == d;
            st = f[4];
            exps = ld && (h1 || (h2 && !st));
            if (exps) tag = "R8";
            else if (ld && h2 && st) tag = "R9";
            else if (d == 0) tag = "R4";
            else if (f[0] && f[1] && (r1 == d || r2 == d)) tag = "R10";
            else tag = "R8";
            #1;
            check(tag, {29'b0, pcHold, ifIdHold, idExBubble}, {29'b0, {3{exps}}}, "stall controls");
          end

    // R8 one bubble: load hits, then no-op enters execute
    exIsLoad = 1; exWe = 1; exRd = 5'd9; idRs1 = 5'd9; idUseRs1 = 1; idUseRs2 = 0; idIsStore = 0; #1;
    check("R8", {31'b0, pcHold}, 32'd1, "stall on load-use");
    exIsLoad = 0; exWe = 0; exRd = '0; #1;
    check("R8", {29'b0, pcHold, ifIdHold, idExBubble}, 32'd0, "stall released after bubble");

    done = 1;
    finishRun();
  end
endmodule